// File: doc/BRIEF.md
# Bus Bridge Byte-Lane Swapper

This block sits in the datapath of a bridge that joins a 32-bit little-endian expansion bus to a 32-bit big-endian system bus. For every transfer it either reverses the byte lanes of the data word or passes them straight through. The byte enables are moved together with the data so that each enable stays with its byte. The result is registered and appears one clock after the input is presented.

Three inputs decide whether a word is swapped. The first is a software-controlled conversion enable. The second is the direction of the transfer: inbound through the target side, or outbound through the master side. The third is a two-bit access-type code.

Memory and I/O traffic follows the conversion enable in both directions. Configuration traffic has its own rule. The inbound target never reorders it. The outbound master always reverses it into little-endian order, so a configuration register holding 0x12345678 reaches the system bus as 0x78563412.

Narrow configuration accesses get no special treatment: the whole word is reversed or left alone, and software repairs the byte order for those accesses.

Top module: `lane_swap_bridge`

## Requirements
- R1: While reset is asserted and on the first clock after it, out_valid, out_data and out_be are all zero.
- R2: out_valid in any cycle equals in_valid one clock earlier.
- R3: An inbound (in_outbound=0) configuration access (in_acc=2'b00) is never swapped, whatever swap_en says: out_data equals in_data and out_be equals in_be.
- R4: An outbound (in_outbound=1) configuration access is always byte-reversed, whatever swap_en says. For example, 0x12345678 becomes 0x78563412.
- R5: Memory (in_acc=2'b01) and I/O (in_acc=2'b10) accesses are byte-reversed in both directions exactly when swap_en=1, and pass unchanged when swap_en=0.
- R6: When a word is swapped, byte enable bit 0 trades places with bit 3 and bit 1 with bit 2; when it is not swapped, out_be equals in_be.
- R7: The swap decision for configuration accesses does not depend on in_be; a partial-lane configuration word is moved across all four lanes just like a full one.
- R8: The unused access code 2'b11 is treated as a memory access, so it is swapped exactly when swap_en=1.
- R9: A clock edge with in_valid=0 leaves out_data and out_be unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 32 | Data word to convert |
| in_be | input | 4 | Byte enables of the input word, bit i covers byte i |
| in_acc | input | 2 | Access type: 00 configuration, 01 memory, 10 I/O, 11 treated as memory |
| in_outbound | input | 1 | 1 = outbound master transfer, 0 = inbound target transfer |
| swap_en | input | 1 | Software conversion enable |
| out_valid | output | 1 | Registered copy of in_valid |
| out_data | output | 32 | Converted data word |
| out_be | output | 4 | Converted byte enables |

## Verification
The assertions assume that every input is at a known level whenever in_valid is high. They also assume that reset is held for at least one clock edge, because the properties compare each output against the inputs sampled on the edge before it. The stimulus meets both assumptions. It holds reset for several cycles and drives every input to a defined value at each falling edge. It covers all access codes, both directions, both enable settings and all sixteen byte-enable patterns, and it inserts idle cycles with changed data so that R9 can be observed.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    typedef enum logic [1:0] {
        ACC_CFG  = 2'b00,
        ACC_MEM  = 2'b01,
        ACC_IO   = 2'b10,
        ACC_RSVD = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/lsb_policy.sv
module lsb_policy
    import lsb_pkg::*;
(
    input  logic [1:0] acc,
    input  logic       outbound,
    input  logic       enable,
    output logic       do_swap
);
    always_comb begin
        unique case (acc_kind_e'(acc))
            ACC_CFG: do_swap = outbound;
            default: do_swap = enable;
        endcase
    end
endmodule

// File: rtl/lsb_lane_rev.sv
module lsb_lane_rev #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*LANE_W +: LANE_W] = din[(LANES-1-g)*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lane_swap_bridge.sv
module lane_swap_bridge
    import lsb_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*LANE_W-1:0] in_data,
    input  logic [LANES-1:0]        in_be,
    input  logic [1:0]              in_acc,
    input  logic                    in_outbound,
    input  logic                    swap_en,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_data,
    output logic [LANES-1:0]        out_be
);
    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
        logic [LANES-1:0] be;
    } stage_t;

    stage_t st_d, st_q;

    logic             swap_now;
    logic [DW-1:0]    data_rev;
    logic [LANES-1:0] be_rev;

    lsb_policy u_policy (
        .acc      (in_acc),
        .outbound (in_outbound),
        .enable   (swap_en),
        .do_swap  (swap_now)
    );

    lsb_lane_rev #(.LANES(LANES), .LANE_W(LANE_W)) u_data_rev (
        .din  (in_data),
        .dout (data_rev)
    );

    lsb_lane_rev #(.LANES(LANES), .LANE_W(1)) u_be_rev (
        .din  (in_be),
        .dout (be_rev)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = swap_now ? data_rev : in_data;
            st_d.be   = swap_now ? be_rev   : in_be;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_be    = st_q.be;

endmodule

// File: rtl/lsb_checker.sv
module lsb_checker #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [LANES*LANE_W-1:0] in_data,
    input logic [LANES-1:0]        in_be,
    input logic [1:0]              in_acc,
    input logic                    in_outbound,
    input logic                    swap_en,
    input logic                    out_valid,
    input logic [LANES*LANE_W-1:0] out_data,
    input logic [LANES-1:0]        out_be
);
    localparam int DW = LANES * LANE_W;

    function automatic logic [DW-1:0] flip_w(input logic [DW-1:0] d);
        logic [DW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = d[(LANES-1-i)*LANE_W +: LANE_W];
        return r;
    endfunction

    function automatic logic [LANES-1:0] flip_b(input logic [LANES-1:0] b);
        logic [LANES-1:0] r;
        for (int i = 0; i < LANES; i++) r[i] = b[LANES-1-i];
        return r;
    endfunction

    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    logic mem_like;
    assign mem_like = (in_acc != 2'b00);

    // R2
    a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (out_valid == $past(in_valid)));

    // R3
    a_r3_cfg_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(in_valid && in_acc == 2'b00 && !in_outbound))
        |-> (out_data == $past(in_data) && out_be == $past(in_be)));

    // R4, R6, R7
    a_r4_cfg_out_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(in_valid && in_acc == 2'b00 && in_outbound))
        |-> (out_data == flip_w($past(in_data)) && out_be == flip_b($past(in_be))));

    // R5, R8
    a_r5_mem_follow_en: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(in_valid && mem_like))
        |-> (out_data == ($past(swap_en) ? flip_w($past(in_data)) : $past(in_data))));

    // R6
    a_r6_be_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(in_valid && mem_like))
        |-> (out_be == ($past(swap_en) ? flip_b($past(in_be)) : $past(in_be))));

    // R9
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(in_valid)) |-> ($stable(out_data) && $stable(out_be)));

endmodule

bind lane_swap_bridge lsb_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_lsb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_be       (in_be),
    .in_acc      (in_acc),
    .in_outbound (in_outbound),
    .swap_en     (swap_en),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_be      (out_be)
);

// File: tb/test_lane_swap_bridge.sv
`timescale 1ns/1ps
module test_lane_swap_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_be = '0;
    logic [1:0]  in_acc = '0;
    logic        in_outbound = 1'b0;
    logic        swap_en = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [3:0]  out_be;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lane_swap_bridge i_lane_swap_bridge (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_be(in_be), .in_acc(in_acc), .in_outbound(in_outbound),
        .swap_en(swap_en), .out_valid(out_valid), .out_data(out_data), .out_be(out_be)
    );

    function automatic logic [31:0] rev32(input logic [31:0] d);
        return ((d >> 24) & 32'h0000_00FF) | ((d >> 8) & 32'h0000_FF00) |
               ((d << 8) & 32'h00FF_0000) | ((d << 24) & 32'hFF00_0000);
    endfunction

    function automatic logic [3:0] rev4(input logic [3:0] b);
        return {b[0], b[1], b[2], b[3]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] acc, input logic ob);
        if (acc == 2'b00) return ob ? "R4/R7" : "R3/R7";
        if (acc == 2'b11) return "R8";
        return "R5";
    endfunction

    task automatic drive(input logic [31:0] d, input logic [3:0] be,
                         input logic [1:0] acc, input logic ob, input logic en);
        logic sw;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_be = be;
        in_acc = acc; in_outbound = ob; swap_en = en;
        // policy under R3/R4/R5/R8
        sw = (acc == 2'b00) ? ob : en;
        @(negedge clk);
        check("R2 out_valid", {31'd0, out_valid}, 32'd1);
        check(tag_of(acc, ob), out_data, sw ? rev32(d) : d);
        check("R6 byte enables", {28'd0, out_be}, {28'd0, sw ? rev4(be) : be});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [3];
        logic [31:0] held_d;
        logic [3:0]  held_b;
        pats[0] = 32'h1234_5678;
        pats[1] = 32'hA5C3_0FF1;
        pats[2] = 32'hDEAD_BEEF;

        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 data", out_data, 32'd0);
        check("R1 be", {28'd0, out_be}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", {31'd0, out_valid}, 32'd0);
        check("R1 data after release", out_data, 32'd0);

        // R4 worked example, enable both ways
        drive(32'h1234_5678, 4'hF, 2'b00, 1'b1, 1'b0);
        check("R4 example", out_data, 32'h7856_3412);
        drive(32'h1234_5678, 4'hF, 2'b00, 1'b0, 1'b1);
        check("R3 example", out_data, 32'h1234_5678);

        // Sweep: access code x direction x enable x byte enables x data
        for (int a = 0; a < 4; a++)
            for (int o = 0; o < 2; o++)
                for (int e = 0; e < 2; e++)
                    for (int b = 0; b < 16; b++)
                        for (int p = 0; p < 3; p++)
                            drive(pats[p] ^ {a[1:0], o[0], e[0], b[3:0], 24'd0},
                                  b[3:0], a[1:0], o[0], e[0]);

        // R9 / R2: idle cycles with changing inputs leave outputs held
        drive(32'hCAFE_0123, 4'b0011, 2'b01, 1'b0, 1'b1);
        held_d = out_data; held_b = out_be;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_data = 32'h1111_0000 + k; in_be = k[3:0];
            in_acc = k[1:0]; in_outbound = k[0]; swap_en = ~k[0];
            @(negedge clk);
            check("R2 idle valid", {31'd0, out_valid}, 32'd0);
            check("R9 hold data", out_data, held_d);
            check("R9 hold be", {28'd0, out_be}, {28'd0, held_b});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule